// File: doc/BRIEF.md
# GF(4096) Composite-Field Multiplier

This block multiplies two 12-bit elements of GF(4096). The field is not built on one flat degree-12 polynomial. It is a quadratic extension of GF(64). Each operand is split into a high 6-bit half (bits 11:6) and a low 6-bit half (bits 5:0). Four GF(64) products are combined into the two halves of the result, and the extension uses the constant 0x21. The field backs a Reed-Solomon code over 12-bit symbols with eight parity symbols, where the first consecutive root has index 1 and the root step is 1.

A mode input picks between two operations:
- **General mode** multiplies `op_a` by `op_b`.
- **Step mode** multiplies `op_a` by the fixed generator constant 0xE01, which a decoder uses to walk from one root to the next. In step mode an input of zero is mapped to one.

A parameter selects one of two timing variants:
- **Combinational:** the result follows the inputs in the same cycle.
- **Registered:** one output register stage is added, and the output valid flag trails the input valid by that one cycle.

Top module: `gf4096_tower_mul`

## Requirements
- R1: GF(64) products reduce by x^6 + x + 1. With both high halves zero, 0x020 times 0x002 gives 0x003.
- R2: The high half of the product (bits 11:6) equals m(ah^al, bh^bl) XOR m(al, bl), where m is the GF(64) product and ah/al are bits 11:6 and 5:0.
- R3: The low half of the product (bits 5:0) equals m(m(ah, bh), 0x21) XOR m(al, bl).
- R4: In general mode (`mode`=0) the product of any two operands matches the bit-serial tower reference.
- R5: In general mode, a zero in either operand gives a zero product.
- R6: In general mode, `op_b`=1 returns `op_a` unchanged.
- R7: In general mode, swapping `op_a` and `op_b` gives the same product.
- R8: In step mode (`mode`=1) the product is `op_a` times 0x0E01, and `op_b` has no effect.
- R9: In step mode an `op_a` of zero gives 0x001.
- R10: With `PIPE`=1, `out_valid` and `product` appear exactly one clock after `in_valid`. With `PIPE`=0 they appear in the same cycle.
- R11: While reset is asserted and after it is released, `out_valid` and `product` are zero until the first valid input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| mode | input | 1 | 0 = general product, 1 = step by generator constant |
| op_a | input | 12 | First operand |
| op_b | input | 12 | Second operand, unused in step mode |
| out_valid | output | 1 | Product valid |
| product | output | 12 | Field product |

## Verification
The properties assume that `mode`, `op_a` and `op_b` are stable and meaningful only in cycles where `in_valid` is high. They also assume the registered variant is in use, so outputs are compared one clock later. The stimulus keeps within these assumptions:
- The bench drives operands only on the falling edge, together with `in_valid`.
- It lowers `in_valid` in idle gaps, so the idle-to-idle relation is exercised as well.
- It fills `op_b` with unrelated values in step mode, so any leakage of that operand would show up against the expected result.

// File: rtl/gft_pkg.sv
package gft_pkg;
    localparam int HALF_W   = 6;
    localparam int ELEM_W   = 2 * HALF_W;
    // x^6 + x + 1 with the x^6 term dropped
    localparam logic [HALF_W-1:0] GF64_TAIL = 6'h03;
    localparam logic [HALF_W-1:0] EXT_CONST = 6'h21;
    localparam logic [ELEM_W-1:0] STEP_CONST = 12'hE01;
    localparam logic [ELEM_W-1:0] STEP_ZERO_MAP = 12'h001;

    typedef enum logic {
        MODE_GENERAL = 1'b0,
        MODE_STEP    = 1'b1
    } gft_mode_e;
endpackage

// File: rtl/gft_gf64_mul.sv
module gft_gf64_mul
    import gft_pkg::*;
(
    input  logic [HALF_W-1:0] x,
    input  logic [HALF_W-1:0] y,
    output logic [HALF_W-1:0] z
);
    // y * alpha^i, reduced (R1)
    logic [HALF_W-1:0] y_pow [HALF_W];

    assign y_pow[0] = y;
    generate
        for (genvar i = 1; i < HALF_W; i++) begin : g_shift
            assign y_pow[i] = {y_pow[i-1][HALF_W-2:0], 1'b0}
                            ^ (y_pow[i-1][HALF_W-1] ? GF64_TAIL : '0);
        end
    endgenerate

    always_comb begin
        z = '0;
        for (int i = 0; i < HALF_W; i++) begin
            if (x[i]) z = z ^ y_pow[i];
        end
    end
endmodule

// File: rtl/gft_tower_core.sv
module gft_tower_core
    import gft_pkg::*;
(
    input  logic [ELEM_W-1:0] a,
    input  logic [ELEM_W-1:0] b,
    output logic [ELEM_W-1:0] p
);
    logic [HALF_W-1:0] a_hi, a_lo, b_hi, b_lo;
    logic [HALF_W-1:0] m_sum, m_lo, m_hi, m_ext;
    logic [HALF_W-1:0] p_hi, p_lo;

    assign a_hi = a[ELEM_W-1:HALF_W];
    assign a_lo = a[HALF_W-1:0];
    assign b_hi = b[ELEM_W-1:HALF_W];
    assign b_lo = b[HALF_W-1:0];

    gft_gf64_mul u_sum (.x(a_hi ^ a_lo), .y(b_hi ^ b_lo), .z(m_sum));
    gft_gf64_mul u_lo  (.x(a_lo),        .y(b_lo),        .z(m_lo));
    gft_gf64_mul u_hi  (.x(a_hi),        .y(b_hi),        .z(m_hi));
    gft_gf64_mul u_ext (.x(m_hi),        .y(EXT_CONST),   .z(m_ext));

    assign p_hi = m_sum ^ m_lo;   // R2
    assign p_lo = m_ext ^ m_lo;   // R3
    assign p    = {p_hi, p_lo};
endmodule

// File: rtl/gft_out_stage.sv
module gft_out_stage
    import gft_pkg::*;
#(
    parameter bit PIPE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              d_valid,
    input  logic [ELEM_W-1:0] d_data,
    output logic              q_valid,
    output logic [ELEM_W-1:0] q_data
);
    generate
        if (PIPE) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q_valid <= 1'b0;
                    q_data  <= '0;
                end else begin
                    q_valid <= d_valid;
                    if (d_valid) q_data <= d_data;
                end
            end
        end else begin : g_comb
            logic unused_clk;
            assign unused_clk = clk;
            assign q_valid = d_valid & rst_n;
            assign q_data  = rst_n ? d_data : '0;
        end
    endgenerate
endmodule

// File: rtl/gf4096_tower_mul.sv
module gf4096_tower_mul
    import gft_pkg::*;
#(
    parameter bit PIPE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              mode,
    input  logic [ELEM_W-1:0] op_a,
    input  logic [ELEM_W-1:0] op_b,
    output logic              out_valid,
    output logic [ELEM_W-1:0] product
);
    gft_mode_e         mode_e;
    logic [ELEM_W-1:0] rhs;
    logic [ELEM_W-1:0] core_p;
    logic [ELEM_W-1:0] sel_p;

    assign mode_e = gft_mode_e'(mode);

    always_comb begin
        unique case (mode_e)
            MODE_GENERAL: rhs = op_b;
            MODE_STEP:    rhs = STEP_CONST;    // R8
            default:      rhs = op_b;
        endcase
    end

    gft_tower_core u_core (.a(op_a), .b(rhs), .p(core_p));

    always_comb begin
        sel_p = core_p;
        if (mode_e == MODE_STEP && op_a == '0) sel_p = STEP_ZERO_MAP; // R9
    end

    gft_out_stage #(.PIPE(PIPE)) u_stage (
        .clk(clk), .rst_n(rst_n),
        .d_valid(in_valid), .d_data(sel_p),
        .q_valid(out_valid), .q_data(product)
    );
endmodule

// File: rtl/gft_checker.sv
module gft_checker
    import gft_pkg::*;
#(
    parameter bit PIPE = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              mode,
    input logic [ELEM_W-1:0] op_a,
    input logic [ELEM_W-1:0] op_b,
    input logic              out_valid,
    input logic [ELEM_W-1:0] product
);
    generate
        if (PIPE) begin : g_reg
            AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R10
            AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R10
            AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && !mode && (op_a == '0 || op_b == '0)) |=> product == '0); // R5
            AST_ONE_OPERAND: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && !mode && op_b == 12'h001) |=> product == $past(op_a)); // R6
            AST_STEP_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && mode && op_a == '0) |=> product == 12'h001); // R9
        end else begin : g_comb
            AST_VALID_SAME: assert property (@(posedge clk) disable iff (!rst_n) in_valid |-> out_valid); // R10
            AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && !mode && (op_a == '0 || op_b == '0)) |-> product == '0); // R5
            AST_ONE_OPERAND: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && !mode && op_b == 12'h001) |-> product == op_a); // R6
            AST_STEP_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && mode && op_a == '0) |-> product == 12'h001); // R9
        end
    endgenerate
endmodule

bind gf4096_tower_mul gft_checker #(.PIPE(PIPE)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .product(product)
);

// File: tb/gf4096_tower_mul_bench.sv
module gf4096_tower_mul_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        mode = 1'b0;
    logic [11:0] op_a = '0;
    logic [11:0] op_b = '0;
    logic        out_valid;
    logic [11:0] product;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    typedef struct {
        logic [11:0] exp;
        string       tag;
        int          issue;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) cyc <= cyc + 1;

    gf4096_tower_mul u_gf4096_tower_mul (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .product(product)
    );

    // bit-serial GF(64) reference, x^6 + x + 1
    function automatic logic [5:0] r64(input logic [5:0] x, input logic [5:0] y);
        logic [6:0] acc;
        logic [6:0] sh;
        acc = '0;
        sh  = {1'b0, y};
        for (int i = 0; i < 6; i++) begin
            if (x[i]) acc = acc ^ sh;
            sh = sh << 1;
            if (sh[6]) sh = sh ^ 7'h43;
        end
        return acc[5:0];
    endfunction

    function automatic logic [11:0] rmul(input logic [11:0] a, input logic [11:0] b);
        logic [5:0] hi, lo;
        hi = r64(a[11:6] ^ a[5:0], b[11:6] ^ b[5:0]) ^ r64(a[5:0], b[5:0]);
        lo = r64(r64(a[11:6], b[11:6]), 6'h21) ^ r64(a[5:0], b[5:0]);
        return {hi, lo};
    endfunction

    task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%03h expected=%03h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic m, input logic [11:0] a, input logic [11:0] b,
                         input logic [11:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1; mode = m; op_a = a; op_b = b;
        it.exp = exp; it.tag = tag; it.issue = cyc;
        sb.push_back(it);
        @(negedge clk);
        in_valid = 1'b0; op_a = 12'h5A5; op_b = 12'hA5A; mode = 1'b0;
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && out_valid) begin
                if (sb.size() == 0) begin
                    check("R10 unexpected valid", 12'h001, 12'h000);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    check(it.tag, product, it.exp);
                    check("R10 latency", 12'(cyc - it.issue), 12'd1);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        check("watchdog", 12'h000, 12'h001);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R11 valid in reset", {11'b0, out_valid}, 12'h000);
        check("R11 product in reset", product, 12'h000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R11 valid after reset", {11'b0, out_valid}, 12'h000);
        check("R11 product after reset", product, 12'h000);

        drive(1'b0, 12'h020, 12'h002, 12'h003, "R1 reduction");
        drive(1'b0, 12'h0C0, 12'h003, 12'h140, "R2 high half");
        drive(1'b0, 12'h040, 12'h040, 12'h061, "R3 low half ext const");
        drive(1'b0, 12'hABC, 12'h000, 12'h000, "R5 zero b");
        drive(1'b0, 12'h000, 12'h7E3, 12'h000, "R5 zero a");
        drive(1'b0, 12'h9D4, 12'h001, 12'h9D4, "R6 identity");
        drive(1'b0, 12'hFFF, 12'hFFF, rmul(12'hFFF, 12'hFFF), "R4 all ones");
        drive(1'b1, 12'h000, 12'h3C7, 12'h001, "R9 step zero");
        drive(1'b1, 12'h001, 12'h000, 12'hE01, "R8 step one");
        drive(1'b1, 12'h5A3, 12'hFFF, rmul(12'h5A3, 12'hE01), "R8 step ignores b");
        drive(1'b1, 12'h5A3, 12'h000, rmul(12'h5A3, 12'hE01), "R8 step ignores b zero");

        for (int i = 0; i < 150; i++) begin
            logic [11:0] a, b;
            a = 12'($urandom);
            b = 12'($urandom);
            drive(1'b0, a, b, rmul(a, b), "R4 random");
            drive(1'b0, b, a, rmul(a, b), "R7 swapped");
            drive(1'b1, a, b, (a == 0) ? 12'h001 : rmul(a, 12'hE01), "R8 random step");
        end

        // back-to-back issue
        @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            item_t it;
            in_valid = 1'b1; mode = 1'b0;
            op_a = 12'(i * 291 + 7); op_b = 12'(i * 613 + 1);
            it.exp = rmul(op_a, op_b); it.tag = "R10 back-to-back"; it.issue = cyc;
            sb.push_back(it);
            @(negedge clk);
        end
        in_valid = 1'b0;

        repeat (5) @(negedge clk);
        check("R10 drained", 12'(sb.size()), 12'h000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule